// File: doc/BRIEF.md
# Capture/Compare Timer with Byte-Pair Access

This block is a 16-bit timebase for a small 8-bit processor subsystem. A free-running counter advances once every four system clocks. Two capture channels record the counter when a chosen edge arrives on their input pins. Two compare channels act on their output pins when the counter reaches a programmed 16-bit value. An 8-bit bus sees every 16-bit quantity as a high/low byte pair.

Software reads and writes these pairs one byte at a time. A 16-bit value stays coherent because touching the high byte of a function suspends that function until its low byte is touched. Event flags record captures, compare matches and counter wrap. Each flag can raise the interrupt line. Software clears a flag with a two-step sequence: it reads the status register, then accesses the low byte that belongs to the flag.

Register addresses, for a 4-bit bus address: 0 counter high, 1 counter low, 2/3 capture 0 high/low, 4/5 capture 1 high/low, 6/7 compare 0 high/low, 8/9 compare 1 high/low, 10 edge select, 11 pin action, 12 interrupt enable, 13 status. Flag and enable bit positions are: bit 0 capture 0, bit 1 capture 1, bit 2 compare 0, bit 3 compare 1, bit 4 counter wrap.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter is 0, both compare registers hold 16'hFFFF, both compare pins are low, the status register reads 0 and `irq` is low.
- R2: The counter holds after k clock edges out of reset the value floor(k/4) modulo 65536, stepping by exactly one. It wraps from 16'hFFFF to 0 and sets status bit 4 on that step.
- R3: A read of the counter high byte (address 0) latches the current low byte. The next read of address 1 returns that latched byte instead of the live one. Without a pending latch, address 1 returns the live low byte.
- R4: Capture inputs pass through two synchronising flops and an edge detector. Edge select register (address 10) bit 2i enables rising edges and bit 2i+1 enables falling edges for channel i. An enabled edge driven just after clock edge c stores floor((c+2)/4) in the channel and sets status bit i. An edge that is not enabled changes neither the value nor the flag.
- R5: Reading a capture high byte blocks new captures on that channel until its low byte is read. Edges arriving while blocked are lost and set no flag.
- R6: On the clock edge where the counter becomes the compare value of channel i, pin i acts according to pin-action register (address 11) bits 2i+1:2i: 00 hold, 01 toggle, 10 drive low, 11 drive high. Status bit 2+i is set on that edge.
- R7: Writing a compare high byte disables matching on that channel until its low byte is written. The pin and flag do not change while matching is disabled.
- R8: A flag is cleared only by a status read (address 13) followed later by an access of its low byte. The low-byte accesses are: capture low read, compare low write, counter low read for the wrap flag. A low-byte access without a prior status read leaves the flag set.
- R9: `irq` is high exactly when some status flag is set and its enable bit in register 12 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| cap_pin | input | 2 | Capture input pins, asynchronous |
| cmp_pin | output | 2 | Compare output pins |
| irq | output | 1 | Interrupt request, active high |

## Verification
Some rules are checked by assertions on every cycle:
- the counter only ever steps by one;
- a captured value is always the counter of the previous cycle;
- a blocked capture channel keeps its value;
- a compare pin moves only on a counter step and never while its channel is disarmed;
- no flag drops without an armed clear;
- the interrupt stays low when every enable is zero.

Other behaviour only the bench scenarios can show:
- the exact cycle of each capture and match;
- the divide-by-four rate and the overflow on the 65536th step, shown on an undivided second instance;
- the coherent low-byte latch across a byte carry;
- the lost edge while a channel is blocked;
- the pin actions;
- the two-step flag clear.

// File: rtl/cct_pkg.sv
// Shared constants and types for the capture/compare timer.
// Assumes a 4-bit register address and two channels of each kind.
package cct_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int N_CAP  = 2;
    localparam int N_CMP  = 2;
    localparam int N_FLG  = N_CAP + N_CMP + 1;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CNT_H = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_L = 4'd1;
    localparam int                A_CAP_BASE = 2;
    localparam int                A_CMP_BASE = A_CAP_BASE + 2 * N_CAP;
    localparam logic [ADDR_W-1:0] A_EDGE  = 4'd10;
    localparam logic [ADDR_W-1:0] A_ACT   = 4'd11;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd12;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd13;

    // Flag positions: captures first, then compares, then wrap.
    localparam int F_CMP0 = N_CAP;
    localparam int F_OVF  = N_CAP + N_CMP;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } cmp_act_e;

    // Address of the high (lo=0) or low (lo=1) byte of a channel.
    function automatic logic [ADDR_W-1:0] pair_addr(int base, int ch, int lo);
        return ADDR_W'(base + 2 * ch + lo);
    endfunction
endpackage

// File: rtl/cct_counter.sv
// Free-running counter behind a power-of-two prescaler, plus the low-byte
// latch that keeps a high-then-low read pair coherent.
// Assumes CNT_W is a multiple of 8 and the high-byte read is a one-cycle strobe.
module cct_counter #(
    parameter int CNT_W    = 16,
    parameter int PRE_LOG2 = 2,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [CNT_W-1:0]  cnt,
    output logic              tick,
    output logic              ovf_evt,
    output logic [BYTE_W-1:0] lo_view
);
    localparam int PRE_W = (PRE_LOG2 > 0) ? PRE_LOG2 : 1;

    logic [PRE_W-1:0]  pre;
    logic [BYTE_W-1:0] lo_buf;
    logic              lo_hold;

    generate
        if (PRE_LOG2 == 0) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            assign tick = &pre;
        end
    endgenerate

    assign ovf_evt = tick && (&cnt);
    assign lo_view = lo_hold ? lo_buf : cnt[BYTE_W-1:0];

    // Prescaler phase: wraps every 2**PRE_LOG2 clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    // Counter step on each prescaler tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Low-byte latch: captured by a high read, released by a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf  <= '0;
            lo_hold <= 1'b0;
        end else if (rd_hi) begin
            lo_buf  <= cnt[BYTE_W-1:0];
            lo_hold <= 1'b1;
        end else if (rd_lo) begin
            lo_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/cct_capture.sv
// One input-capture channel: two-flop synchroniser, edge detector with
// per-edge enables, 16-bit latch, and a block set by a high-byte read.
// Assumes pin is asynchronous to clk and cnt is the registered counter.
module cct_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             rd_hi,
    input  logic             rd_lo,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] value,
    output logic             blocked,
    output logic             evt
);
    logic [1:0] sync;
    logic       prev;
    logic       rise, fall;

    assign rise = sync[1] & ~prev;
    assign fall = ~sync[1] & prev;
    assign evt  = !blocked && ((rise && rise_en) || (fall && fall_en));

    // Synchroniser and previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= '0;
            prev <= 1'b0;
        end else begin
            sync <= {sync[0], pin};
            prev <= sync[1];
        end
    end

    // Capture latch loads the counter on an enabled, unblocked edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (evt) value <= cnt;
    end

    // Block flag: set by a high-byte read, cleared by a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)     blocked <= 1'b0;
        else if (rd_hi) blocked <= 1'b1;
        else if (rd_lo) blocked <= 1'b0;
    end
endmodule

// File: rtl/cct_compare.sv
// One output-compare channel: 16-bit compare register written a byte at a
// time, disarmed by a high write and rearmed by a low write. The match
// fires on the tick that makes the counter equal to the compare value.
// Assumes tick and cnt come from cct_counter.
module cct_compare
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  cmp_act_e          act,
    output logic [CNT_W-1:0]  value,
    output logic              armed,
    output logic              pin,
    output logic              evt
);
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt + 1'b1;
    assign evt      = armed && tick && (cnt_next == value);

    // Compare register and arm state from the byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '1;
            armed <= 1'b1;
        end else if (wr_hi) begin
            value[CNT_W-1:BYTE_W] <= wdata;
            armed                 <= 1'b0;
        end else if (wr_lo) begin
            value[BYTE_W-1:0] <= wdata;
            armed             <= 1'b1;
        end
    end

    // Pin action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else if (evt) begin
            case (act)
                ACT_TOGGLE: pin <= ~pin;
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                default:    pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/cc_timer.sv
// Capture/compare timer top: bus decode, configuration registers, event
// flags with the status-read-then-low-access clear, and the interrupt.
// Assumes at most one bus access per cycle. Read side effects act on the
// clock edge that ends the access.
module cc_timer
    import cct_pkg::*;
#(
    parameter int PRE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_CAP-1:0]  cap_pin,
    output logic [N_CMP-1:0]  cmp_pin,
    output logic              irq
);
    logic rd_s, wr_s;
    assign rd_s = bus_sel & ~bus_wr;
    assign wr_s = bus_sel &  bus_wr;

    logic [CNT_W-1:0]              cnt_val;
    logic                          tick, ovf_evt;
    logic [BYTE_W-1:0]             cnt_lo_view;
    logic                          cnt_lo_rd;
    logic [N_CAP-1:0][CNT_W-1:0]   cap_val;
    logic [N_CAP-1:0]              cap_blk, cap_evt, cap_lo_rd;
    logic [N_CMP-1:0][CNT_W-1:0]   cmp_val;
    logic [N_CMP-1:0]              cmp_arm, cmp_evt, cmp_lo_wr;
    logic [2*N_CAP-1:0]            edge_cfg;
    logic [2*N_CMP-1:0]            act_cfg;
    logic [N_FLG-1:0]              ien, flags, armed, flg_set, lo_acc, clr;
    logic                          stat_rd;

    assign cnt_lo_rd = rd_s && (bus_addr == A_CNT_L);
    assign stat_rd   = rd_s && (bus_addr == A_STAT);

    cct_counter #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2), .BYTE_W(BYTE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_s && (bus_addr == A_CNT_H)),
        .rd_lo   (cnt_lo_rd),
        .cnt     (cnt_val),
        .tick    (tick),
        .ovf_evt (ovf_evt),
        .lo_view (cnt_lo_view)
    );

    for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cap
        assign cap_lo_rd[gi] = rd_s && (bus_addr == pair_addr(A_CAP_BASE, gi, 1));
        cct_capture #(.CNT_W(CNT_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (cap_pin[gi]),
            .rise_en (edge_cfg[2*gi]),
            .fall_en (edge_cfg[2*gi+1]),
            .rd_hi   (rd_s && (bus_addr == pair_addr(A_CAP_BASE, gi, 0))),
            .rd_lo   (cap_lo_rd[gi]),
            .cnt     (cnt_val),
            .value   (cap_val[gi]),
            .blocked (cap_blk[gi]),
            .evt     (cap_evt[gi])
        );
    end

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        assign cmp_lo_wr[gi] = wr_s && (bus_addr == pair_addr(A_CMP_BASE, gi, 1));
        cct_compare #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hi (wr_s && (bus_addr == pair_addr(A_CMP_BASE, gi, 0))),
            .wr_lo (cmp_lo_wr[gi]),
            .wdata (bus_wdata),
            .tick  (tick),
            .cnt   (cnt_val),
            .act   (cmp_act_e'(act_cfg[2*gi +: 2])),
            .value (cmp_val[gi]),
            .armed (cmp_arm[gi]),
            .pin   (cmp_pin[gi]),
            .evt   (cmp_evt[gi])
        );
    end

    assign flg_set = {ovf_evt, cmp_evt, cap_evt};
    assign lo_acc  = {cnt_lo_rd, cmp_lo_wr, cap_lo_rd};
    assign clr     = armed & lo_acc;
    assign irq     = |(flags & ien);

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cfg <= '0;
            act_cfg  <= '0;
            ien      <= '0;
        end else if (wr_s) begin
            if (bus_addr == A_EDGE) edge_cfg <= bus_wdata[2*N_CAP-1:0];
            if (bus_addr == A_ACT)  act_cfg  <= bus_wdata[2*N_CMP-1:0];
            if (bus_addr == A_IEN)  ien      <= bus_wdata[N_FLG-1:0];
        end
    end

    // Event flags; a status read arms the set flags for clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~clr) | flg_set;
            if (stat_rd) armed <= flags;
            else         armed <= armed & ~clr;
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd_s) begin
            case (bus_addr)
                A_CNT_H: bus_rdata = cnt_val[CNT_W-1:BYTE_W];
                A_CNT_L: bus_rdata = cnt_lo_view;
                A_EDGE:  bus_rdata = BYTE_W'(edge_cfg);
                A_ACT:   bus_rdata = BYTE_W'(act_cfg);
                A_IEN:   bus_rdata = BYTE_W'(ien);
                A_STAT:  bus_rdata = BYTE_W'(flags);
                default: bus_rdata = '0;
            endcase
            for (int i = 0; i < N_CAP; i++) begin
                if (bus_addr == pair_addr(A_CAP_BASE, i, 0)) bus_rdata = cap_val[i][CNT_W-1:BYTE_W];
                if (bus_addr == pair_addr(A_CAP_BASE, i, 1)) bus_rdata = cap_val[i][BYTE_W-1:0];
            end
            for (int i = 0; i < N_CMP; i++) begin
                if (bus_addr == pair_addr(A_CMP_BASE, i, 0)) bus_rdata = cmp_val[i][CNT_W-1:BYTE_W];
                if (bus_addr == pair_addr(A_CMP_BASE, i, 1)) bus_rdata = cmp_val[i][BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cc_timer_chk.sv
// Temporal checks on the capture/compare timer, bound into every instance.
// Assumes the signal names of cc_timer.
module cc_timer_chk
    import cct_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq,
    input logic [N_CMP-1:0]            cmp_pin,
    input logic [CNT_W-1:0]            cnt_val,
    input logic [N_CAP-1:0][CNT_W-1:0] cap_val,
    input logic [N_CAP-1:0]            cap_blk,
    input logic [N_CMP-1:0]            cmp_arm,
    input logic [N_FLG-1:0]            flags,
    input logic [N_FLG-1:0]            armed,
    input logic [N_FLG-1:0]            ien
);
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != $past(cnt_val)) |-> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap_chk
        assert_cap_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_val[i] != $past(cap_val[i])) |-> (cap_val[i] == $past(cnt_val)));
        assert_cap_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cap_blk[i]) |-> (cap_val[i] == $past(cap_val[i])));
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp_chk
        assert_cmp_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_pin[i] != $past(cmp_pin[i])) |-> (cnt_val != $past(cnt_val)));
        assert_cmp_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cmp_arm[i]) |-> $stable(cmp_pin[i]));
    end

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags & ~$past(armed)) == '0));

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind cc_timer cc_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .cmp_pin (cmp_pin),
    .cnt_val (cnt_val),
    .cap_val (cap_val),
    .cap_blk (cap_blk),
    .cmp_arm (cmp_arm),
    .flags   (flags),
    .armed   (armed),
    .ien     (ien)
);

// File: tb/cc_timer_bench.sv
// Self-checking bench: a divide-by-four instance for the bus scenarios and
// an undivided instance that reaches counter wrap quickly.
module cc_timer_bench;
    import cct_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       bus_sel, bus_wr;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [1:0] cap_in, cmp_out;
    logic       irq;
    logic [3:0] f_addr;
    logic [7:0] f_rdata;
    logic [1:0] f_cmp;
    logic       f_irq;

    cc_timer u_cc_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_in), .cmp_pin(cmp_out), .irq(irq)
    );

    cc_timer #(.PRE_LOG2(0)) u_cc_timer_fast (
        .clk(clk), .rst_n(rst_n), .bus_sel(1'b1), .bus_wr(1'b0),
        .bus_addr(f_addr), .bus_wdata(8'h00), .bus_rdata(f_rdata),
        .cap_pin(2'b00), .cmp_pin(f_cmp), .irq(f_irq)
    );

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int last_cyc;
    logic [7:0] q;

    function automatic int ecnt(int c);
        return (c >> 2) & 16'hFFFF;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #3;
        q = bus_rdata;
        last_cyc = cyc;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        acc(1'b0, a, 8'h00);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic cap_read(input int ch, output int v);
        rd(pair_addr(A_CAP_BASE, ch, 0));
        v = int'(q) << 8;
        rd(pair_addr(A_CAP_BASE, ch, 1));
        v = v | int'(q);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 120000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int c, v, hc, t, t1, t2;
        logic exp0;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        cap_in = 2'b00; f_addr = A_STAT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 cmp pins", int'(cmp_out), 0);
        check("R1 irq", int'(irq), 0);
        rd(pair_addr(A_CMP_BASE, 0, 0)); check("R1 cmp0 high", q, 8'hFF);
        rd(pair_addr(A_CMP_BASE, 1, 1)); check("R1 cmp1 low", q, 8'hFF);
        rd(A_STAT);  check("R1 status", q, 0);
        rd(A_CNT_H); check("R1 counter high", q, 0);
        hc = last_cyc;
        rd(A_CNT_L); check("R3 latched low after reset", q, ecnt(hc) & 8'hFF);

        // R2: counter rate sweep over varied gaps
        for (int k = 0; k < 24; k++) begin
            repeat (k % 5) @(negedge clk);
            rd(A_CNT_L);
            check("R2 live low byte", q, ecnt(last_cyc) & 8'hFF);
        end

        // R3: coherent pair across a byte carry
        while (cyc < 1020) @(negedge clk);
        rd(A_CNT_H); hc = last_cyc;
        check("R3 high byte", q, ecnt(hc) >> 8);
        repeat (12) @(negedge clk);
        rd(A_CNT_L);
        check("R3 latched low byte", q, ecnt(hc) & 8'hFF);
        rd(A_CNT_H); check("R3 high after carry", q, ecnt(last_cyc) >> 8);
        rd(A_CNT_L); check("R3 second latched low", q, ecnt(last_cyc - 1) & 8'hFF);

        // R4: rising-edge capture on channel 0, falling on channel 1
        wr(A_EDGE, 8'h09);
        wr(A_IEN, 8'h01);
        @(negedge clk); cap_in[0] = 1'b1; c = cyc;
        @(negedge clk); @(negedge clk);
        check("R9 irq before capture", int'(irq), 0);
        @(negedge clk);
        check("R4 R9 irq on capture", int'(irq), 1);
        cap_read(0, v); check("R4 capture 0 value", v, ecnt(c + 2));
        rd(A_STAT); check("R8 flag kept without status read", q, 8'h01);
        rd(pair_addr(A_CAP_BASE, 0, 1));
        rd(A_STAT); check("R8 capture flag cleared", q, 0);
        check("R9 irq after clear", int'(irq), 0);

        @(negedge clk); cap_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        rd(A_STAT); check("R4 disabled edge sets no flag", q, 0);
        cap_read(0, t); check("R4 disabled edge keeps value", t, v);

        @(negedge clk); cap_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        rd(A_STAT); check("R4 rise ignored on channel 1", q, 0);
        @(negedge clk); cap_in[1] = 1'b0; c = cyc;
        repeat (6) @(negedge clk);
        cap_read(1, v); check("R4 capture 1 falling", v, ecnt(c + 2));
        rd(A_STAT); check("R4 capture 1 flag", q, 8'h02);
        rd(pair_addr(A_CAP_BASE, 1, 1));

        // R5: high read blocks the channel
        rd(pair_addr(A_CAP_BASE, 1, 0));
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (6) @(negedge clk);
        rd(A_STAT); check("R5 no flag while blocked", q, 0);
        rd(pair_addr(A_CAP_BASE, 1, 1));
        check("R5 value kept while blocked", q, v & 8'hFF);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        @(negedge clk); cap_in[1] = 1'b0; c = cyc;
        repeat (6) @(negedge clk);
        cap_read(1, v); check("R5 capture after unblock", v, ecnt(c + 2));

        // R4: both-edge sweep on channel 0 with growing gaps
        wr(A_EDGE, 8'h0B);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); cap_in[0] = ~cap_in[0]; c = cyc;
            repeat (4 + i) @(negedge clk);
            cap_read(0, v);
            check("R4 both-edge capture", v, ecnt(c + 2));
        end
        rd(A_STAT);
        rd(pair_addr(A_CAP_BASE, 0, 1));
        rd(pair_addr(A_CAP_BASE, 1, 1));
        wr(A_IEN, 8'h00);

        // R6: toggle action at exact match cycles
        wr(A_ACT, 8'h0D);
        exp0 = 1'b0;
        for (int j = 0; j < 3; j++) begin
            t = ecnt(cyc) + 8 + j;
            wr(pair_addr(A_CMP_BASE, 0, 0), 8'(t >> 8));
            wr(pair_addr(A_CMP_BASE, 0, 1), 8'(t));
            @(negedge clk);
            while (cyc < 4 * t - 1) @(negedge clk);
            check("R6 pin before match", int'(cmp_out[0]), int'(exp0));
            @(negedge clk);
            exp0 = ~exp0;
            check("R6 pin toggled on match", int'(cmp_out[0]), int'(exp0));
        end
        rd(A_STAT); check("R6 compare 0 flag", (q >> 2) & 1, 1);
        wr(pair_addr(A_CMP_BASE, 0, 1), 8'(t));
        rd(A_STAT); check("R8 compare flag cleared by low write", (q >> 2) & 1, 0);

        // R6: drive-low action
        wr(A_ACT, 8'h0E);
        t = ecnt(cyc) + 8;
        wr(pair_addr(A_CMP_BASE, 0, 0), 8'(t >> 8));
        wr(pair_addr(A_CMP_BASE, 0, 1), 8'(t));
        @(negedge clk);
        while (cyc < 4 * t - 1) @(negedge clk);
        check("R6 pin high before clear", int'(cmp_out[0]), 1);
        @(negedge clk);
        check("R6 pin driven low", int'(cmp_out[0]), 0);

        // R7: high write disarms channel 1 until its low write
        wr(A_IEN, 8'h08);
        t1 = ecnt(cyc) + 8;
        wr(pair_addr(A_CMP_BASE, 1, 0), 8'(t1 >> 8));
        wr(pair_addr(A_CMP_BASE, 1, 1), 8'(t1));
        wr(pair_addr(A_CMP_BASE, 1, 0), 8'(t1 >> 8));
        while (cyc < 4 * t1 + 8) @(negedge clk);
        check("R7 no action while disarmed", int'(cmp_out[1]), 0);
        check("R7 R9 no irq while disarmed", int'(irq), 0);
        rd(A_STAT); check("R7 no flag while disarmed", (q >> 3) & 1, 0);
        t2 = ecnt(cyc) + 8;
        wr(pair_addr(A_CMP_BASE, 1, 0), 8'(t2 >> 8));
        wr(pair_addr(A_CMP_BASE, 1, 1), 8'(t2));
        @(negedge clk);
        while (cyc < 4 * t2 - 1) @(negedge clk);
        check("R7 pin low before rearmed match", int'(cmp_out[1]), 0);
        @(negedge clk);
        check("R6 R7 drive-high on rearmed match", int'(cmp_out[1]), 1);
        check("R9 irq on enabled compare flag", int'(irq), 1);

        // R2 R8: wrap on the undivided instance
        while (cyc < 65535) @(negedge clk);
        #3;
        check("R2 no wrap flag before 65536 steps", (int'(f_rdata) >> 4) & 1, 0);
        @(negedge clk); #3;
        check("R2 wrap flag on step 65536", (int'(f_rdata) >> 4) & 1, 1);
        @(negedge clk); f_addr = A_CNT_L;
        @(negedge clk); f_addr = A_STAT;
        #3;
        check("R8 wrap flag cleared by counter low read", (int'(f_rdata) >> 4) & 1, 0);

        summary();
        $finish;
    end
endmodule